// File: doc/BRIEF.md
# Directory-Protocol Cache Node Controller

This block sits at one processor node of a directory-coherent multiprocessor and keeps a small direct-mapped set of single-word cache lines coherent. Each line is held as Invalid, Shared (read-only copy) or Exclusive (sole, writable and possibly dirty copy). The processor presents one access at a time and stalls until it completes. Hits finish in the cycle they are presented. A miss becomes a request message to the home directory, and the access finishes when the data reply comes back.

The home directory reaches the node only through explicit messages: invalidate, fetch, and fetch-with-invalidate. An owner answers a fetch by returning its data in a write-back message. When a miss displaces an Exclusive line, the node first writes the victim back and then sends its own request. There is no bus snooping. A single incoming message channel carries both the coherence commands and the data replies, and one outgoing channel carries the node's messages, one per cycle, tagged with the node's processor id.

Top module: `ccn_node_ctrl`

## Requirements
- R1: After reset every line is Invalid, `outValid` is low and `cpuDone` is low.
- R2: A read to a Shared or Exclusive line whose tag (address bits above the low `log2(LINES)` index bits) matches, or a write to a matching Exclusive line, raises `cpuDone` combinationally in the cycle the request is seen and sends no message. A write hit stores `cpuWdata` in the line, and a read hit returns the stored word on `cpuRdata`.
- R3: A read that misses, where the indexed line is not an Exclusive line of another tag, sends a read-miss message (type 1) with `outPid` = NODE_ID and the request address, in the cycle after the request. When the data reply (type 7) arrives, `cpuDone` rises in that same cycle with the reply data on `cpuRdata`, and the line becomes Shared.
- R4: A write to an Invalid, absent or Shared line sends a write-miss message (type 2). On the reply the line becomes Exclusive and holds `cpuWdata`.
- R5: An invalidate (type 4) for a Shared line makes it Invalid. An invalidate for an Exclusive line has no effect.
- R6: A fetch (type 5) for an Exclusive line sends, in the next cycle, a data write-back message (type 3) carrying the fetched address and the line's data, and leaves the line Shared.
- R7: A fetch-with-invalidate (type 6) for an Exclusive line sends a data write-back (type 3) with the line's data and leaves the line Invalid.
- R8: A miss whose indexed line is Exclusive with another tag first sends a write-back of the victim (address = victim tag and index, data = victim word). The read-miss or write-miss follows in the next cycle, unless an incoming coherence message claims that cycle, in which case it follows once the channel is free.
- R9: A coherence message (types 4–6) is serviced in the cycle it arrives, in every state including while a reply is awaited. The processor is stalled during that cycle (`cpuDone` low). A message for an address with no valid matching line, or in a state it does not act on, changes nothing.
- R10: `cpuDone` rises only for a hit or for the awaited reply. A data reply arriving when no miss is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until `cpuDone` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Access completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with `cpuDone` on a read |
| outValid | output | 1 | Outgoing message valid this cycle |
| outType | output | 3 | 1 read-miss, 2 write-miss, 3 data write-back |
| outPid | output | PID_W | Processor id of this node |
| outAddr | output | ADDR_W | Message address |
| outData | output | DATA_W | Write-back data (zero for misses) |
| inValid | input | 1 | Incoming message valid this cycle |
| inType | input | 3 | 4 invalidate, 5 fetch, 6 fetch-invalidate, 7 data reply |
| inAddr | input | ADDR_W | Address of the incoming message |
| inData | input | DATA_W | Data of a reply |

## Verification
The hardest cases to reach are a coherence message landing on the exact cycle between a victim write-back and its deferred miss request, and a fetch arriving while the node itself waits for a reply on another line. Both need an Exclusive line to be set up beforehand in a second index. The stimulus first builds the owned lines through ordinary write misses. It then starts a conflicting access and injects the directory message at a chosen cycle offset inside that access. A behavioural per-cycle model in the bench tracks every line and the expected message stream, so the deferral and the ordering of messages are checked on every clock.

// File: rtl/ccn_pkg.sv
`timescale 1ns/1ps
package ccn_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } lineState_e;

  // one code space for both directions of the message channel
  typedef enum logic [2:0] {
    MSG_NONE       = 3'd0,
    MSG_RD_MISS    = 3'd1,
    MSG_WR_MISS    = 3'd2,
    MSG_DATA_WB    = 3'd3,
    MSG_INVAL      = 3'd4,
    MSG_FETCH      = 3'd5,
    MSG_FETCH_INV  = 3'd6,
    MSG_DATA_REPLY = 3'd7
  } msgKind_e;

  typedef enum logic [1:0] {
    ADDR_CPU    = 2'd0,
    ADDR_VICTIM = 2'd1,
    ADDR_IN     = 2'd2
  } addrSel_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SEND_MISS = 2'd1,
    ST_WAIT      = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       lineWr;     // write line state
    logic       useInIdx;   // select line by incoming address
    lineState_e newState;
    logic       tagWr;      // load cpu tag
    logic       dataWr;     // load line word
    logic       dataFromIn; // word source: inData (else cpuWdata)
    logic       send;       // emit a message next cycle
    msgKind_e   sendKind;
    addrSel_e   addrSel;
  } dpCtl_t;

endpackage

// File: rtl/ccn_datapath.sv
`timescale 1ns/1ps
module ccn_datapath
  import ccn_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int LINES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output lineState_e        cpuLineState,
  output logic              cpuTagHit,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_e        inLineState,
  output logic              inTagHit,
  output logic              outValid,
  output msgKind_e          outKind,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_e        stQ   [LINES];
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];

  logic [IDX_W-1:0] cpuIdx, inIdx, selIdx;
  logic [TAG_W-1:0] cpuTag, inTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign inIdx  = inAddr[IDX_W-1:0];
  assign inTag  = inAddr[ADDR_W-1:IDX_W];
  assign selIdx = ctl.useInIdx ? inIdx : cpuIdx;

  assign cpuLineState = stQ[cpuIdx];
  assign cpuTagHit    = (tagQ[cpuIdx] == cpuTag);
  assign cpuLineData  = dataQ[cpuIdx];
  assign inLineState  = stQ[inIdx];
  assign inTagHit     = (tagQ[inIdx] == inTag);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hitSel;
    assign hitSel = (selIdx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ[g]   <= LINE_INV;
        tagQ[g]  <= '0;
        dataQ[g] <= '0;
      end else begin
        if (ctl.lineWr && hitSel) stQ[g]   <= ctl.newState;
        if (ctl.tagWr  && hitSel) tagQ[g]  <= cpuTag;
        if (ctl.dataWr && hitSel) dataQ[g] <= ctl.dataFromIn ? inData : cpuWdata;
      end
    end
  end

  logic [ADDR_W-1:0] msgAddr;
  always_comb begin
    unique case (ctl.addrSel)
      ADDR_VICTIM: msgAddr = {tagQ[cpuIdx], cpuIdx};
      ADDR_IN:     msgAddr = inAddr;
      default:     msgAddr = cpuAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= MSG_NONE;
      outAddr  <= '0;
      outData  <= '0;
    end else begin
      outValid <= ctl.send;
      outKind  <= ctl.send ? ctl.sendKind : MSG_NONE;
      outAddr  <= ctl.send ? msgAddr : '0;
      outData  <= (ctl.send && ctl.sendKind == MSG_DATA_WB) ? dataQ[selIdx] : '0;
    end
  end

  // a write-back only ever leaves an owned line
  AST_WB_FROM_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.send && ctl.sendKind == MSG_DATA_WB) |-> (stQ[selIdx] == LINE_EXC)); // R6
  // a line that is filled by a write reply becomes owned and readable next cycle
  AST_FILL_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineWr && ctl.dataWr && ctl.newState == LINE_EXC && !ctl.useInIdx)
      |=> (stQ[$past(cpuIdx)] == LINE_EXC)); // R4

endmodule

// File: rtl/ccn_control.sv
`timescale 1ns/1ps
module ccn_control
  import ccn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       inValid,
  input  msgKind_e   inKind,
  input  lineState_e cpuLineState,
  input  logic       cpuTagHit,
  input  lineState_e inLineState,
  input  logic       inTagHit,
  output dpCtl_t     ctl,
  output logic       cpuDone,
  output logic       replySel
);

  ctlState_e fsmQ, fsmD;
  logic cohIn, isReply, inPresent, cpuHit;

  assign cohIn     = inValid && (inKind == MSG_INVAL || inKind == MSG_FETCH ||
                                 inKind == MSG_FETCH_INV);
  assign isReply   = inValid && (inKind == MSG_DATA_REPLY);
  assign inPresent = inTagHit && (inLineState != LINE_INV);
  assign cpuHit    = cpuTagHit && (cpuLineState != LINE_INV) &&
                     (!cpuWe || cpuLineState == LINE_EXC);

  always_comb begin
    ctl      = '0;
    fsmD     = fsmQ;
    cpuDone  = 1'b0;
    replySel = 1'b0;
    if (cohIn) begin
      ctl.useInIdx = 1'b1;
      ctl.addrSel  = ADDR_IN;
      unique case (inKind)
        MSG_INVAL: begin
          if (inPresent && inLineState == LINE_SHR) begin
            ctl.lineWr   = 1'b1;
            ctl.newState = LINE_INV;
          end
        end
        MSG_FETCH, MSG_FETCH_INV: begin
          if (inPresent && inLineState == LINE_EXC) begin
            ctl.lineWr   = 1'b1;
            ctl.newState = (inKind == MSG_FETCH) ? LINE_SHR : LINE_INV;
            ctl.send     = 1'b1;
            ctl.sendKind = MSG_DATA_WB;
          end
        end
        default: ;
      endcase
    end else begin
      unique case (fsmQ)
        ST_IDLE: begin
          if (cpuReq) begin
            if (cpuHit) begin
              cpuDone    = 1'b1;
              ctl.dataWr = cpuWe;
            end else if (cpuLineState == LINE_EXC && !cpuTagHit) begin
              ctl.lineWr   = 1'b1;
              ctl.newState = LINE_INV;
              ctl.send     = 1'b1;
              ctl.sendKind = MSG_DATA_WB;
              ctl.addrSel  = ADDR_VICTIM;
              fsmD         = ST_SEND_MISS;
            end else begin
              ctl.lineWr   = 1'b1;
              ctl.newState = LINE_INV;
              ctl.tagWr    = 1'b1;
              ctl.send     = 1'b1;
              ctl.sendKind = cpuWe ? MSG_WR_MISS : MSG_RD_MISS;
              fsmD         = ST_WAIT;
            end
          end
        end
        ST_SEND_MISS: begin
          ctl.lineWr   = 1'b1;
          ctl.newState = LINE_INV;
          ctl.tagWr    = 1'b1;
          ctl.send     = 1'b1;
          ctl.sendKind = cpuWe ? MSG_WR_MISS : MSG_RD_MISS;
          fsmD         = ST_WAIT;
        end
        ST_WAIT: begin
          if (isReply) begin
            cpuDone        = 1'b1;
            replySel       = 1'b1;
            ctl.lineWr     = 1'b1;
            ctl.newState   = cpuWe ? LINE_EXC : LINE_SHR;
            ctl.tagWr      = 1'b1;
            ctl.dataWr     = 1'b1;
            ctl.dataFromIn = !cpuWe;
            fsmD           = ST_IDLE;
          end
        end
        default: fsmD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsmQ <= ST_IDLE;
    else       fsmQ <= fsmD;
  end

  AST_VICTIM_BEFORE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (fsmQ == ST_SEND_MISS && $past(fsmQ) != ST_SEND_MISS)
      |-> $past(ctl.send && ctl.sendKind == MSG_DATA_WB)); // R8
  AST_MISS_THEN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.send && (ctl.sendKind == MSG_RD_MISS || ctl.sendKind == MSG_WR_MISS))
      |=> (fsmQ == ST_WAIT)); // R3
  AST_COH_STALLS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    cohIn |-> !cpuDone); // R9
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> (fsmQ == ST_IDLE)); // R2

endmodule

// File: rtl/ccn_node_ctrl.sv
`timescale 1ns/1ps
module ccn_node_ctrl
  import ccn_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int LINES   = 4,
  parameter int PID_W   = 4,
  parameter int NODE_ID = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              outValid,
  output logic [2:0]        outType,
  output logic [PID_W-1:0]  outPid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              inValid,
  input  logic [2:0]        inType,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData
);

  dpCtl_t            ctl;
  msgKind_e          inKind, outKind;
  lineState_e        cpuLineState, inLineState;
  logic              cpuTagHit, inTagHit, replySel;
  logic [DATA_W-1:0] cpuLineData;

  assign inKind   = msgKind_e'(inType);
  assign outType  = outKind;
  assign outPid   = PID_W'(NODE_ID);
  assign cpuRdata = replySel ? inData : cpuLineData;

  ccn_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .inValid      (inValid),
    .inKind       (inKind),
    .cpuLineState (cpuLineState),
    .cpuTagHit    (cpuTagHit),
    .inLineState  (inLineState),
    .inTagHit     (inTagHit),
    .ctl          (ctl),
    .cpuDone      (cpuDone),
    .replySel     (replySel)
  );

  ccn_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cpuAddr      (cpuAddr),
    .cpuWdata     (cpuWdata),
    .inAddr       (inAddr),
    .inData       (inData),
    .cpuLineState (cpuLineState),
    .cpuTagHit    (cpuTagHit),
    .cpuLineData  (cpuLineData),
    .inLineState  (inLineState),
    .inTagHit     (inTagHit),
    .outValid     (outValid),
    .outKind      (outKind),
    .outAddr      (outAddr),
    .outData      (outData)
  );

endmodule

// File: tb/ccn_node_ctrl_tb.sv
`timescale 1ns/1ps
module ccn_node_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuDone;
  logic [31:0] cpuRdata;
  logic        outValid;
  logic [2:0]  outType;
  logic [3:0]  outPid;
  logic [11:0] outAddr;
  logic [31:0] outData;
  logic        inValid = 1'b0;
  logic [2:0]  inType = '0;
  logic [11:0] inAddr = '0;
  logic [31:0] inData = '0;

  always #10 clk = ~clk;

  ccn_node_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .outValid(outValid), .outType(outType), .outPid(outPid), .outAddr(outAddr),
    .outData(outData), .inValid(inValid), .inType(inType), .inAddr(inAddr),
    .inData(inData)
  );

  int checks = 0;
  int errors = 0;
  bit lastDone;

  // behavioural model: 0 invalid, 1 shared, 2 exclusive; mode 0 idle, 1 victim sent, 2 waiting
  int          mSt   [4];
  logic [9:0]  mTag  [4];
  logic [31:0] mData [4];
  int          mMode = 0;
  bit          eOV = 0;
  int          eOT = 0;
  logic [11:0] eOA = '0;
  logic [31:0] eOD = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input string rq);
    bit cohIn, rep, eDone, pres, match, missNow;
    logic [31:0] eRd;
    int i, stI, stV, tI, dI;
    logic [9:0]  tV;
    logic [31:0] dV;
    int nMode, nOT;
    bit nOV;
    logic [11:0] nOA;
    logic [31:0] nOD;
    #1;
    cohIn = inValid && inType >= 3'd4 && inType <= 3'd6;
    rep   = inValid && inType == 3'd7;
    eDone = 0; eRd = '0; stI = -1; stV = 0; tI = -1; tV = '0; dI = -1; dV = '0;
    nMode = mMode; nOV = 0; nOT = 0; nOA = '0; nOD = '0; missNow = 0;
    if (cohIn) begin
      i = int'(inAddr[1:0]);
      pres = mSt[i] != 0 && mTag[i] == inAddr[11:2];
      if (inType == 3'd4 && pres && mSt[i] == 1) begin stI = i; stV = 0; end
      if ((inType == 3'd5 || inType == 3'd6) && pres && mSt[i] == 2) begin
        stI = i; stV = (inType == 3'd5) ? 1 : 0;
        nOV = 1; nOT = 3; nOA = inAddr; nOD = mData[i];
      end
    end else if (mMode == 0 && cpuReq) begin
      i = int'(cpuAddr[1:0]);
      match = mSt[i] != 0 && mTag[i] == cpuAddr[11:2];
      if (match && (!cpuWe || mSt[i] == 2)) begin
        eDone = 1; eRd = mData[i];
        if (cpuWe) begin dI = i; dV = cpuWdata; end
      end else if (mSt[i] == 2) begin
        stI = i; stV = 0; nOV = 1; nOT = 3; nOA = {mTag[i], cpuAddr[1:0]};
        nOD = mData[i]; nMode = 1;
      end else missNow = 1;
    end else if (mMode == 1) missNow = 1;
    else if (mMode == 2 && rep) begin
      i = int'(cpuAddr[1:0]);
      eDone = 1; eRd = inData; stI = i; stV = cpuWe ? 2 : 1;
      tI = i; tV = cpuAddr[11:2]; dI = i; dV = cpuWe ? cpuWdata : inData; nMode = 0;
    end
    if (missNow) begin
      i = int'(cpuAddr[1:0]);
      stI = i; stV = 0; tI = i; tV = cpuAddr[11:2];
      nOV = 1; nOT = cpuWe ? 2 : 1; nOA = cpuAddr; nOD = '0; nMode = 2;
    end
    chk(cpuDone === eDone, rq, "cpuDone", 32'(cpuDone), 32'(eDone));
    if (eDone && !cpuWe) chk(cpuRdata === eRd, rq, "cpuRdata", cpuRdata, eRd);
    chk(outValid === eOV, rq, "outValid", 32'(outValid), 32'(eOV));
    if (eOV) begin
      chk(outType === 3'(eOT), rq, "outType", 32'(outType), 32'(eOT));
      chk(outAddr === eOA, rq, "outAddr", 32'(outAddr), 32'(eOA));
      chk(outData === eOD, rq, "outData", outData, eOD);
      chk(outPid === 4'd5, rq, "outPid", 32'(outPid), 32'd5);
    end
    lastDone = cpuDone;
    @(posedge clk);
    if (stI >= 0) mSt[stI] = stV;
    if (tI >= 0) mTag[tI] = tV;
    if (dI >= 0) mData[dI] = dV;
    mMode = nMode; eOV = nOV; eOT = nOT; eOA = nOA; eOD = nOD;
    @(negedge clk);
  endtask

  task automatic cpuAccess(input bit we, input logic [11:0] a, input logic [31:0] wd,
                           input logic [31:0] rep, input int injAt, input logic [2:0] injT,
                           input logic [11:0] injA, input string rq);
    bit pend = 0;
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    for (int k = 0; k < 20; k++) begin
      if (k == injAt) begin inValid = 1; inType = injT; inAddr = injA; inData = '0; end
      else if (pend) begin inValid = 1; inType = 3'd7; inAddr = a; inData = rep; pend = 0; end
      else inValid = 0;
      step(rq);
      if (lastDone) break;
      if (outValid && (outType == 3'd1 || outType == 3'd2)) pend = 1;
    end
    chk(lastDone, rq, "access completed", 32'(lastDone), 32'd1);
    cpuReq = 0; inValid = 0;
  endtask

  task automatic sendMsg(input logic [2:0] t, input logic [11:0] a, input string rq);
    cpuReq = 0; inValid = 1; inType = t; inAddr = a; inData = 32'hDEAD_0000;
    step(rq);
    inValid = 0;
    step(rq);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R1", "outValid in reset", 32'(outValid), 0);
    chk(cpuDone === 1'b0, "R1", "cpuDone in reset", 32'(cpuDone), 0);
    rstN = 1;
    @(negedge clk);
    step("R1");
    // R3 read miss then R2 read hit
    cpuAccess(0, 12'h010, 0, 32'h1111_0001, -1, 0, 0, "R3");
    cpuAccess(0, 12'h010, 0, 0, -1, 0, 0, "R2");
    // R4 upgrade from Shared, then write hit and read hit
    cpuAccess(1, 12'h010, 32'h2222_0002, 32'h0, -1, 0, 0, "R4");
    cpuAccess(1, 12'h010, 32'h3333_0003, 0, -1, 0, 0, "R2");
    cpuAccess(0, 12'h010, 0, 0, -1, 0, 0, "R2");
    // R6 fetch on owned line, then a write must miss again
    sendMsg(3'd5, 12'h010, "R6");
    cpuAccess(1, 12'h010, 32'h4444_0004, 32'h0, -1, 0, 0, "R6");
    // R7 fetch-invalidate, then read misses
    sendMsg(3'd6, 12'h010, "R7");
    cpuAccess(0, 12'h010, 0, 32'h5555_0005, -1, 0, 0, "R7");
    // R5 invalidate shared line, absent address, owned line
    sendMsg(3'd4, 12'h010, "R5");
    cpuAccess(0, 12'h010, 0, 32'h6666_0006, -1, 0, 0, "R5");
    sendMsg(3'd4, 12'h7F1, "R9");
    cpuAccess(1, 12'h021, 32'h7777_0007, 0, -1, 0, 0, "R4");
    sendMsg(3'd4, 12'h021, "R5");
    cpuAccess(0, 12'h021, 0, 0, -1, 0, 0, "R5");
    sendMsg(3'd5, 12'h031, "R9");
    // R8 victim write-back before read miss, then shared victim, then owned victim on write
    cpuAccess(0, 12'h031, 0, 32'h8888_0008, -1, 0, 0, "R8");
    cpuAccess(1, 12'h041, 32'h9999_0009, 0, -1, 0, 0, "R4");
    cpuAccess(1, 12'h051, 32'hAAAA_000A, 0, -1, 0, 0, "R8");
    // R9 fetch serviced while waiting on another line
    cpuAccess(1, 12'h012, 32'hBBBB_000B, 0, -1, 0, 0, "R4");
    cpuAccess(0, 12'h013, 0, 32'hCCCC_000C, 2, 3'd5, 12'h012, "R9");
    // R8/R9 coherence message in the cycle between victim write-back and miss
    cpuAccess(1, 12'h012, 32'hDDDD_000D, 0, -1, 0, 0, "R4");
    cpuAccess(1, 12'h061, 32'hEEEE_000E, 0, 1, 3'd6, 12'h012, "R8");
    // R9 hit stalled by a same-cycle message for an absent line
    cpuAccess(0, 12'h061, 0, 0, 0, 3'd4, 12'h7F0, "R9");
    // R10 stray reply ignored
    cpuReq = 0; inValid = 1; inType = 3'd7; inAddr = 12'h061; inData = 32'hFFFF_FFFF;
    step("R10");
    inValid = 0;
    step("R10");
    cpuAccess(0, 12'h061, 0, 0, -1, 0, 0, "R10");
    chk(cpuRdata === 32'hEEEE_000E || !lastDone, "R10", "data kept", cpuRdata, 32'hEEEE_000E);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule